// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a synchronous DRAM from power-up to its idle state. It runs once after every reset. During a long timed pause it keeps clock enable and every data-mask line high and places NOP commands on the bus. After the pause it issues one precharge of all banks and a counted run of auto refresh commands. It then writes the mode register, with a timed gap after each command. When the sequence ends it raises a done flag and deselects the device, so a memory controller can take over the command bus.

Every wait is given in time and turned into clock cycles at elaboration, rounding up, from a clock-period parameter. The mode register value is built from parameters for CAS latency, burst type, burst length and write mode, and is placed on the address pins during the mode register set command.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted and until done, sd_cke is 1, every sd_dqm bit is 1, and the command {sd_cs_n,sd_ras_n,sd_cas_n,sd_we_n} is NOP (4'b0111); init_done is 0.
- R2: After reset is released, at least PAUSE_CYC = ceil(PAUSE_NS*1000/CLK_PS) cycles of NOP pass before the first other command, and the internal reset synchronizer adds no more than 3 cycles to this.
- R3: The first command after the pause is precharge (4'b0010) with sd_addr[10] = 1, selecting all banks, and it is issued exactly once per sequence.
- R4: The first auto refresh (4'b0001) comes exactly ceil(20000/CLK_PS) cycles after the precharge (at least 2), with NOP in between.
- R5: Exactly NUM_REF (default 8) auto refresh commands are issued, and each one after the first comes exactly ceil(67500/CLK_PS) cycles after the one before it.
- R6: The mode register set (4'b0000) comes exactly ceil(67500/CLK_PS) cycles after the last refresh, is issued exactly once, and drives sd_ba = 0.
- R7: The mode word on sd_addr holds the burst length code in bits 2:0 (1->000, 2->001, 4->010, 8->011, full page->111), the burst type in bit 3 (1 = interleaved), the CAS latency in bits 6:4 (2->010, 3->011), and single-location write in bit 9. All other address bits are 0.
- R8: init_done rises exactly 2 cycles after the mode register set and then stays high. While it is high the command is deselect (4'b1111), sd_cke is 1 and sd_dqm is 0.
- R9: Asserting reset at any point, including after done, returns the outputs at once to the R1 state, and the full sequence runs again after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | ADDR_W | Address pins; A10 during precharge, mode word during mode set |
| sd_dqm | output | DQM_W | Data mask lines |
| init_done | output | 1 | High once the device is initialized |

## Verification
The block has no data inputs, so the assertions rely on only one thing: reset behaves as a clean asynchronous assertion and is held low for at least one clock. They also take the command spacing to be measured from the internal synchronized reset onward. The stimulus varies only the reset: it uses random hold lengths and random abort points, placed in the pause, the refresh loop and after done. Two instances with different clock-period and mode parameters are checked side by side against spacings and mode words computed in the bench.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    CMD_MRS  = 4'b0000,
    CMD_REF  = 4'b0001,
    CMD_PRE  = 4'b0010,
    CMD_NOP  = 4'b0111,
    CMD_DESL = 4'b1111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_PRE,
    ST_PRE_GAP,
    ST_REF,
    ST_REF_GAP,
    ST_MRS,
    ST_MRS_GAP,
    ST_DONE
  } init_state_e;

  // cycles covering a duration, rounded up
  function automatic int unsigned cyc_ceil(int unsigned dur_ps, int unsigned per_ps);
    return (dur_ps + per_ps - 1) / per_ps;
  endfunction

  function automatic logic [15:0] mode_word(int unsigned cas_lat, int unsigned burst_len,
                                            bit interleave, bit single_wr);
    logic [15:0] w;
    logic [2:0]  blc;
    case (burst_len)
      1:       blc = 3'b000;
      2:       blc = 3'b001;
      4:       blc = 3'b010;
      8:       blc = 3'b011;
      default: blc = 3'b111;
    endcase
    w      = '0;
    w[2:0] = blc;
    w[3]   = interleave;
    w[6:4] = 3'(cas_lat);
    w[9]   = single_wr;
    return w;
  endfunction

endpackage

// File: rtl/sdram_init_rstsync.sv
module sdram_init_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int unsigned   CW      = 8,
  parameter logic [CW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired = (cnt_q == '0);
  assign cnt_en  = load || !expired;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= RST_VAL;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int unsigned   CW      = 8,
  parameter int unsigned   NUM_REF = 8,
  parameter logic [CW-1:0] TRP_LD  = '0,
  parameter logic [CW-1:0] TRC_LD  = '0,
  parameter logic [CW-1:0] MRS_LD  = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          expired,
  output logic          load,
  output logic [CW-1:0] load_val,
  output init_state_e   state
);
  localparam int unsigned RW = $clog2(NUM_REF + 1);

  init_state_e st_q, st_d;
  logic [RW-1:0] ref_q, ref_d;
  logic          ref_en;

  always_comb begin
    st_d     = st_q;
    ref_d    = ref_q + 1'b1;
    ref_en   = 1'b0;
    load     = 1'b0;
    load_val = '0;
    case (st_q)
      ST_PAUSE:   if (expired) st_d = ST_PRE;
      ST_PRE: begin
        load     = 1'b1;
        load_val = TRP_LD;
        st_d     = ST_PRE_GAP;
      end
      ST_PRE_GAP: if (expired) st_d = ST_REF;
      ST_REF: begin
        load     = 1'b1;
        load_val = TRC_LD;
        ref_en   = 1'b1;
        st_d     = ST_REF_GAP;
      end
      ST_REF_GAP: if (expired) st_d = (ref_q == RW'(NUM_REF)) ? ST_MRS : ST_REF;
      ST_MRS: begin
        load     = 1'b1;
        load_val = MRS_LD;
        st_d     = ST_MRS_GAP;
      end
      ST_MRS_GAP: if (expired) st_d = ST_DONE;
      default:    st_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_PAUSE;
      ref_q <= '0;
    end else begin
      st_q <= st_d;
      if (ref_en) ref_q <= ref_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_PS       = 5000,
  parameter int unsigned PAUSE_NS     = 200000,
  parameter int unsigned TRP_PS       = 20000,
  parameter int unsigned TRC_PS       = 67500,
  parameter int unsigned NUM_REF      = 8,
  parameter int unsigned CAS_LAT      = 3,
  parameter int unsigned BURST_LEN    = 8,
  parameter bit          INTERLEAVE   = 1'b0,
  parameter bit          SINGLE_WRITE = 1'b0,
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned DQM_W        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [1:0]        sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic              init_done
);
  localparam int unsigned PAUSE_RAW = cyc_ceil(PAUSE_NS * 1000, CLK_PS);
  localparam int unsigned PAUSE_CYC = (PAUSE_RAW < 1) ? 1 : PAUSE_RAW;
  localparam int unsigned TRP_RAW   = cyc_ceil(TRP_PS, CLK_PS);
  localparam int unsigned TRP_GAP   = (TRP_RAW < 2) ? 2 : TRP_RAW;
  localparam int unsigned TRC_RAW   = cyc_ceil(TRC_PS, CLK_PS);
  localparam int unsigned TRC_GAP   = (TRC_RAW < 2) ? 2 : TRC_RAW;
  localparam int unsigned MRS_GAP   = 2;
  localparam int unsigned BIG_CYC   = (PAUSE_CYC > TRC_GAP) ? PAUSE_CYC : TRC_GAP;
  localparam int unsigned CW        = $clog2(BIG_CYC + 1);
  localparam logic [15:0] MODE_FULL = mode_word(CAS_LAT, BURST_LEN, INTERLEAVE, SINGLE_WRITE);

  logic          rst_sync_n;
  logic          expired;
  logic          load;
  logic [CW-1:0] load_val;
  init_state_e   state;
  sd_cmd_e       cmd;

  sdram_init_rstsync #(.STAGES(2)) u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sdram_init_timer #(
    .CW      (CW),
    .RST_VAL (CW'(PAUSE_CYC - 1))
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  sdram_init_fsm #(
    .CW      (CW),
    .NUM_REF (NUM_REF),
    .TRP_LD  (CW'(TRP_GAP - 2)),
    .TRC_LD  (CW'(TRC_GAP - 2)),
    .MRS_LD  (CW'(MRS_GAP - 2))
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .expired  (expired),
    .load     (load),
    .load_val (load_val),
    .state    (state)
  );

  // command and address decode from the sequencer state
  always_comb begin
    sd_addr = '0;
    case (state)
      ST_PRE: begin
        cmd         = CMD_PRE;
        sd_addr[10] = 1'b1;
      end
      ST_REF:  cmd = CMD_REF;
      ST_MRS: begin
        cmd     = CMD_MRS;
        sd_addr = MODE_FULL[ADDR_W-1:0];
      end
      ST_DONE: cmd = CMD_DESL;
      default: cmd = CMD_NOP;
    endcase
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_ba     = 2'b00;
  assign sd_cke    = 1'b1;
  assign init_done = (state == ST_DONE);
  assign sd_dqm    = {DQM_W{!init_done}};
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DQM_W   = 4,
  parameter int unsigned TRP_GAP = 4,
  parameter int unsigned TRC_GAP = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [1:0]        ba,
  input logic [ADDR_W-1:0] addr,
  input logic [DQM_W-1:0]  dqm,
  input logic              done
);
  localparam logic [3:0] C_MRS = 4'b0000;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_DES = 4'b1111;

  logic [3:0]  cmd;
  logic [15:0] since_q;
  logic        last_ref_q;
  logic        is_cmd;

  assign cmd    = {cs_n, ras_n, cas_n, we_n};
  assign is_cmd = (cmd != C_NOP) && (cmd != C_DES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q    <= 16'hFFFF;
      last_ref_q <= 1'b0;
    end else if (is_cmd) begin
      since_q    <= 16'd1;
      last_ref_q <= (cmd == C_REF);
    end else if (since_q != 16'hFFFF) begin
      since_q <= since_q + 16'd1;
    end
  end

  a_r1_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (cke && (&dqm)));

  a_r3_pre_all: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_PRE) |-> addr[10]);

  a_r4_pre_to_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_REF && !last_ref_q) |-> (since_q == 16'(TRP_GAP)));

  a_r5_ref_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_REF && last_ref_q) |-> (since_q == 16'(TRC_GAP)));

  a_r6_mrs_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_MRS) |-> (last_ref_q && since_q == 16'(TRC_GAP) && ba == 2'b00));

  a_r7_mode_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_MRS) |-> (addr[8:7] == 2'b00 && addr[ADDR_W-1:10] == '0 &&
                        (addr[6:4] == 3'b010 || addr[6:4] == 3'b011)));

  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  a_r8_released: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && cke && dqm == '0));
endmodule

bind sdram_init_seq sdram_init_chk #(
  .ADDR_W  (ADDR_W),
  .DQM_W   (DQM_W),
  .TRP_GAP (TRP_GAP),
  .TRC_GAP (TRC_GAP)
) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .cke   (sd_cke),
  .cs_n  (sd_cs_n),
  .ras_n (sd_ras_n),
  .cas_n (sd_cas_n),
  .we_n  (sd_we_n),
  .ba    (sd_ba),
  .addr  (sd_addr),
  .dqm   (sd_dqm),
  .done  (init_done)
);

// File: tb/sdram_init_seq_bench.sv
`timescale 1ns/1ps
module sdram_init_seq_bench;
  localparam int unsigned PAUSE_NS = 2000;
  localparam int unsigned RUN_LEN  = 560;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic        a_cke, a_cs, a_ras, a_cas, a_we, a_done;
  logic [1:0]  a_ba;
  logic [11:0] a_addr;
  logic [3:0]  a_dqm;
  logic        b_cke, b_cs, b_ras, b_cas, b_we, b_done;
  logic [1:0]  b_ba;
  logic [12:0] b_addr;
  logic [3:0]  b_dqm;

  sdram_init_seq #(.CLK_PS(5000), .PAUSE_NS(PAUSE_NS), .CAS_LAT(3), .BURST_LEN(8),
                   .INTERLEAVE(1'b0), .SINGLE_WRITE(1'b1), .ADDR_W(12)) u_sdram_init_seq (
    .clk(clk), .rst_n(rst_n), .sd_cke(a_cke), .sd_cs_n(a_cs), .sd_ras_n(a_ras),
    .sd_cas_n(a_cas), .sd_we_n(a_we), .sd_ba(a_ba), .sd_addr(a_addr),
    .sd_dqm(a_dqm), .init_done(a_done));

  sdram_init_seq #(.CLK_PS(7500), .PAUSE_NS(PAUSE_NS), .CAS_LAT(2), .BURST_LEN(4),
                   .INTERLEAVE(1'b1), .SINGLE_WRITE(1'b0), .ADDR_W(13)) u_sdram_init_seq_alt (
    .clk(clk), .rst_n(rst_n), .sd_cke(b_cke), .sd_cs_n(b_cs), .sd_ras_n(b_ras),
    .sd_cas_n(b_cas), .sd_we_n(b_we), .sd_ba(b_ba), .sd_addr(b_addr),
    .sd_dqm(b_dqm), .init_done(b_done));

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  int pause_e[2], trp_e[2], trc_e[2], mode_e[2];
  int last_t[2], mrs_t[2], n_pre[2], n_ref[2], n_mrs[2];
  bit seen_done[2];

  function automatic int ceil_cyc(int dur_ps, int per_ps);
    int q = dur_ps / per_ps;
    if (q * per_ps < dur_ps) q = q + 1;
    return q;
  endfunction

  function automatic int exp_mode(int cl, int bl, int il, int sw);
    int code = (bl == 0) ? 7 : $clog2(bl);
    return code + il * 8 + cl * 16 + sw * 512;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic observe(int i, int t, logic [3:0] c, logic [12:0] a, logic [1:0] b,
                         logic ck, logic [3:0] dm, logic dn);
    check(ck == 1'b1, "R1", "cke level", ck, 1);
    check(dm == (dn ? 4'h0 : 4'hF), dn ? "R8" : "R1", "dqm lines", dm, dn ? 0 : 15);
    if (dn && !seen_done[i]) begin
      seen_done[i] = 1'b1;
      check(t == mrs_t[i] + 2, "R8", "done delay after mode set", t, mrs_t[i] + 2);
    end
    if (!dn && seen_done[i]) check(1'b0, "R8", "done dropped", 0, 1);
    case (c)
      4'b0111: check(!dn, "R8", "NOP after done", c, 15);
      4'b1111: check(dn, "R8", "deselect before done", c, 7);
      4'b0010: begin
        check(t >= pause_e[i] && t <= pause_e[i] + 3, "R2", "pause length", t, pause_e[i]);
        check(a[10] == 1'b1, "R3", "precharge A10", a[10], 1);
        check(n_pre[i] == 0 && n_ref[i] == 0, "R3", "precharge order", n_pre[i], 0);
        n_pre[i]++;
        last_t[i] = t;
      end
      4'b0001: begin
        if (n_ref[i] == 0)
          check(n_pre[i] == 1 && t - last_t[i] == trp_e[i], "R4", "precharge to refresh", t - last_t[i], trp_e[i]);
        else
          check(t - last_t[i] == trc_e[i], "R5", "refresh spacing", t - last_t[i], trc_e[i]);
        n_ref[i]++;
        last_t[i] = t;
      end
      4'b0000: begin
        check(n_ref[i] == 8, "R5", "refreshes before mode set", n_ref[i], 8);
        check(t - last_t[i] == trc_e[i], "R6", "refresh to mode set", t - last_t[i], trc_e[i]);
        check(b == 2'b00, "R6", "bank bits at mode set", b, 0);
        check(int'(a) == mode_e[i], "R7", "mode word", a, mode_e[i]);
        n_mrs[i]++;
        mrs_t[i] = t;
        last_t[i] = t;
      end
      default: check(1'b0, "R1", "unexpected command", c, 7);
    endcase
  endtask

  task automatic check_idle(string req);
    check({a_cs, a_ras, a_cas, a_we} == 4'b0111 && a_cke && a_dqm == 4'hF && !a_done,
          req, "reset outputs A", {a_cs, a_ras, a_cas, a_we}, 7);
    check({b_cs, b_ras, b_cas, b_we} == 4'b0111 && b_cke && b_dqm == 4'hF && !b_done,
          req, "reset outputs B", {b_cs, b_ras, b_cas, b_we}, 7);
  endtask

  task automatic do_run(int hold, int abort_at);
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    check_idle("R9");
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check_idle("R1");
    end
    for (int i = 0; i < 2; i++) begin
      last_t[i] = 0; mrs_t[i] = -100; n_pre[i] = 0; n_ref[i] = 0; n_mrs[i] = 0;
      seen_done[i] = 1'b0;
    end
    rst_n = 1'b1;
    for (int t = 1; t <= RUN_LEN; t++) begin
      @(negedge clk);
      observe(0, t, {a_cs, a_ras, a_cas, a_we}, {1'b0, a_addr}, a_ba, a_cke, a_dqm, a_done);
      observe(1, t, {b_cs, b_ras, b_cas, b_we}, b_addr, b_ba, b_cke, b_dqm, b_done);
      if (abort_at > 0 && t == abort_at) return;
    end
    for (int i = 0; i < 2; i++) begin
      check(n_pre[i] == 1, "R3", "precharge count", n_pre[i], 1);
      check(n_ref[i] == 8, "R5", "refresh count", n_ref[i], 8);
      check(n_mrs[i] == 1, "R6", "mode set count", n_mrs[i], 1);
      check(seen_done[i], "R8", "done reached", seen_done[i], 1);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    pause_e[0] = ceil_cyc(PAUSE_NS * 1000, 5000);
    pause_e[1] = ceil_cyc(PAUSE_NS * 1000, 7500);
    trp_e[0] = ceil_cyc(20000, 5000);
    trp_e[1] = ceil_cyc(20000, 7500);
    trc_e[0] = ceil_cyc(67500, 5000);
    trc_e[1] = ceil_cyc(67500, 7500);
    mode_e[0] = exp_mode(3, 8, 0, 1);
    mode_e[1] = exp_mode(2, 4, 1, 0);
    rst_n = 1'b0;
    do_run(5, 0);
    for (int r = 0; r < 4; r++)
      do_run(2 + int'($urandom % 8), 1 + int'($urandom % (RUN_LEN - 40)));
    do_run(3, 20);
    do_run(3, RUN_LEN - 5);
    do_run(4, 0);
    finish_up();
  end

  initial begin
    #1000000;
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end
endmodule